// File: doc/BRIEF.md
# Vectored Interrupt Entry Controller

This block carries out interrupt entry for a small processor core. On every instruction boundary the execution unit announces, the block looks at a reset request, a non-maskable request (NMI) and six maskable request lines, and picks at most one of them. It saves the interrupted program counter and status word into a save pair. It records a cause code and then presents the handler address with a one-cycle load strobe. The execution unit loads that address into its program counter.

The block owns the processor status word (PSW). It uses three bits of that word: interrupt-disable (ID, bit 5), exception-in-progress (EP, bit 6) and NMI-in-service (NP, bit 7). NMI entry and maskable entry each have their own save pair, so an NMI can arrive in the middle of a maskable handler without destroying that handler's return state.

While an NMI handler is running, a new NMI is not taken. Instead a single deferred flag records it. Any further NMI arriving in that window is lost. When the execution unit signals the NMI return, NP is cleared and the deferred NMI is entered at the next boundary. The execution unit can also overwrite the PSW through a write port; this models a load-status instruction.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the PSW is 0x20 (only ID set). The cause register, all four save registers, the handler address and the deferred flag are zero, and the load strobe is low.
- R2: Requests are evaluated only in a cycle with `boundary` high. Each accepted entry raises `pc_load` for exactly the one cycle after that boundary, with `new_pc` valid in the same cycle. Without a boundary no entry takes place.
- R3: A reset request at a boundary produces handler address 0, sets the PSW to 0x20, zeroes the whole cause register and clears the deferred-NMI flag. The save registers are left unchanged.
- R4: An accepted NMI stores `cur_pc` in the NMI saved-PC register and the pre-entry PSW in the NMI saved-PSW register. It sets NP and ID, clears EP, and writes 0x0010 into cause[31:16] while cause[15:0] is kept. The handler address is 0x10.
- R5: An NMI request at a boundary while NP is set is not entered. It sets the deferred flag, and the NMI save registers keep their values.
- R6: While the deferred flag is set, further NMI requests are dropped, not counted. After the NMI return, exactly one deferred NMI is entered.
- R7: An accepted maskable request stores `cur_pc` and the pre-entry PSW in the maskable save pair. It writes the vector into cause[15:0] while cause[31:16] is kept, sets ID and clears EP.
- R8: Maskable line i has vector 0x80 + 0x10·i. Line 0 is the timer overflow (0x80), lines 1 to 4 are the external pins (0x90, 0xA0, 0xB0, 0xC0) and line 5 is the compare match (0xD0). When several lines request together, the lowest-numbered line wins.
- R9: Maskable requests are ignored while ID is set. NMI and reset are taken regardless of ID. Writing the PSW through the write port (for example writing 0x00 to clear ID) re-enables maskable entry.
- R10: Priority at a boundary is reset first, then NMI (a new request or a deferred one, if NP is clear), then maskable requests. Only one entry happens per boundary.
- R11: A pulse on `nmi_ret` clears NP without itself causing an entry. If the deferred flag is set, the deferred NMI is entered at the next boundary and the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary | input | 1 | Instruction-boundary strobe; entry is decided only in this cycle |
| cur_pc | input | 32 | PC to save on entry |
| rst_req | input | 1 | Reset request |
| nmi_req | input | 1 | Non-maskable request |
| mi_req | input | 6 | Maskable request lines, line 0 has highest priority |
| psw_wr_en | input | 1 | PSW write strobe from the execution unit |
| psw_wr_data | input | 8 | PSW write value |
| nmi_ret | input | 1 | NMI return pulse, clears NP |
| psw | output | 8 | Current PSW (bit 5 ID, bit 6 EP, bit 7 NP) |
| nmi_pend | output | 1 | Deferred-NMI flag |
| cause | output | 32 | Cause register: [31:16] NMI code, [15:0] maskable code |
| nmi_save_pc | output | 32 | PC saved on NMI entry |
| nmi_save_psw | output | 8 | PSW saved on NMI entry |
| mi_save_pc | output | 32 | PC saved on maskable entry |
| mi_save_psw | output | 8 | PSW saved on maskable entry |
| new_pc | output | 32 | Handler address |
| pc_load | output | 1 | One-cycle strobe: load `new_pc` |

## Verification
The bench goes after the NMI arriving while NP is set. A design that entered it anyway would overwrite the NMI save pair. A design that counted repeats would take a second deferred entry after the return. It also raises all six maskable lines together and each line alone: a reversed priority encoder returns 0xD0 instead of 0xA0, and an off-by-one vector step shows in every single-line case. Reset, NMI and maskable requests are presented in one boundary. A wrong ordering loads the wrong handler or leaves the cause field stale. Requests are also shown with ID set or without a boundary strobe, where any `pc_load` is an error.

// File: rtl/irq_entry_pkg.sv
// Shared definitions for the interrupt entry controller: PSW bit
// positions, reset value, NMI vector and the entry selection type.
package irq_entry_pkg;

    localparam int PSW_W      = 8;
    localparam int PSW_ID_BIT = 5;
    localparam int PSW_EP_BIT = 6;
    localparam int PSW_NP_BIT = 7;
    localparam logic [PSW_W-1:0] PSW_RESET_VAL = 8'h20;

    localparam int CAUSE_W   = 32;
    localparam int CAUSE_HALF = CAUSE_W / 2;
    localparam logic [CAUSE_HALF-1:0] NMI_CAUSE_CODE = 16'h0010;
    localparam int NMI_VECTOR = 32'h10;

    // Which kind of entry is taken at the current boundary
    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_RESET = 2'd1,
        SEL_NMI   = 2'd2,
        SEL_MASK  = 2'd3
    } entry_sel_e;

endpackage

// File: rtl/irq_arbiter.sv
// Priority arbiter. Purely combinational. At a boundary it chooses
// reset, then NMI (a new or deferred one, if NP is clear), then the
// lowest-numbered maskable line (if ID is clear). It also flags an NMI
// that has to be deferred because NP is set.
// Assumes: the request inputs are stable while boundary is high.
module irq_arbiter
    import irq_entry_pkg::*;
#(
    parameter int NUM_MI = 6,
    localparam int IDX_W = (NUM_MI > 1) ? $clog2(NUM_MI) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary,
    input  logic              rst_req,
    input  logic              nmi_req,
    input  logic              nmi_pend,
    input  logic              psw_id,
    input  logic              psw_np,
    input  logic [NUM_MI-1:0] mi_req,
    output entry_sel_e        sel,
    output logic [IDX_W-1:0]  mi_idx,
    output logic              nmi_defer
);

    logic [NUM_MI-1:0] grant;
    logic [NUM_MI:0]   blocked;

    // Prefix chain: a line is granted only if no lower line requests
    assign blocked[0] = 1'b0;
    for (genvar g = 0; g < NUM_MI; g++) begin : g_prio
        assign grant[g]     = mi_req[g] & ~blocked[g];
        assign blocked[g+1] = blocked[g] | mi_req[g];
    end

    // Encode the one-hot grant into a line index
    always_comb begin
        mi_idx = '0;
        for (int i = 0; i < NUM_MI; i++) begin
            if (grant[i]) mi_idx = IDX_W'(i);
        end
    end

    // Choose the entry kind by fixed priority
    always_comb begin
        if (boundary && rst_req)
            sel = SEL_RESET;
        else if (boundary && (nmi_req || nmi_pend) && !psw_np)
            sel = SEL_NMI;
        else if (boundary && blocked[NUM_MI] && !psw_id)
            sel = SEL_MASK;
        else
            sel = SEL_NONE;
    end

    // An NMI that meets NP already set is held back
    assign nmi_defer = boundary && !rst_req && nmi_req && psw_np;

    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R8
    grant_is_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mi_req[0] |-> grant[0]);

endmodule

// File: rtl/irq_psw_ctrl.sv
// Holds the PSW and the deferred-NMI flag. Entry takes precedence over
// a PSW write, and a PSW write takes precedence over an NMI return in
// the same cycle.
// Assumes: sel comes from irq_arbiter for the current cycle.
module irq_psw_ctrl
    import irq_entry_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  entry_sel_e       sel,
    input  logic             nmi_defer,
    input  logic             psw_wr_en,
    input  logic [PSW_W-1:0] psw_wr_data,
    input  logic             nmi_ret,
    output logic [PSW_W-1:0] psw,
    output logic             nmi_pend
);

    logic [PSW_W-1:0] psw_nx;
    logic             pend_nx;

    // Next PSW value by entry kind, then write port, then NMI return
    always_comb begin
        psw_nx = psw;
        unique case (sel)
            SEL_RESET: psw_nx = PSW_RESET_VAL;
            SEL_NMI: begin
                psw_nx[PSW_ID_BIT] = 1'b1;
                psw_nx[PSW_EP_BIT] = 1'b0;
                psw_nx[PSW_NP_BIT] = 1'b1;
            end
            SEL_MASK: begin
                psw_nx[PSW_ID_BIT] = 1'b1;
                psw_nx[PSW_EP_BIT] = 1'b0;
            end
            default: begin
                if (psw_wr_en)
                    psw_nx = psw_wr_data;
                else if (nmi_ret)
                    psw_nx[PSW_NP_BIT] = 1'b0;
            end
        endcase
    end

    // Next deferred flag: cleared when NMI or reset is taken, set on a deferral
    always_comb begin
        pend_nx = nmi_pend;
        if (sel == SEL_RESET || sel == SEL_NMI)
            pend_nx = 1'b0;
        else if (nmi_defer)
            pend_nx = 1'b1;
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psw      <= PSW_RESET_VAL;
            nmi_pend <= 1'b0;
        end else begin
            psw      <= psw_nx;
            nmi_pend <= pend_nx;
        end
    end

    // R5
    pend_needs_np_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_pend) |-> $past(psw[PSW_NP_BIT]));

    // R11
    pend_leaves_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_pend) |-> psw[PSW_NP_BIT] || psw == PSW_RESET_VAL);

endmodule

// File: rtl/irq_save_regs.sv
// Save pairs, cause register and handler address. On entry it captures
// the interrupted PC and the pre-entry PSW, updates the cause field of
// the entry kind, and drives new_pc with a one-cycle pc_load.
// Assumes: psw is the value before this cycle's entry.
module irq_save_regs
    import irq_entry_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int NUM_MI   = 6,
    parameter int VEC_BASE = 32'h80,
    parameter int VEC_STEP = 32'h10,
    localparam int IDX_W   = (NUM_MI > 1) ? $clog2(NUM_MI) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  entry_sel_e         sel,
    input  logic [IDX_W-1:0]   mi_idx,
    input  logic [PC_W-1:0]    cur_pc,
    input  logic [PSW_W-1:0]   psw,
    output logic [CAUSE_W-1:0] cause,
    output logic [PC_W-1:0]    nmi_save_pc,
    output logic [PSW_W-1:0]   nmi_save_psw,
    output logic [PC_W-1:0]    mi_save_pc,
    output logic [PSW_W-1:0]   mi_save_psw,
    output logic [PC_W-1:0]    new_pc,
    output logic               pc_load
);

    logic [PC_W-1:0] mi_vec;

    // Maskable vector from the granted line index
    assign mi_vec = PC_W'(VEC_BASE) + PC_W'(VEC_STEP) * PC_W'(mi_idx);

    // Capture save state, cause and handler address on entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause        <= '0;
            nmi_save_pc  <= '0;
            nmi_save_psw <= '0;
            mi_save_pc   <= '0;
            mi_save_psw  <= '0;
            new_pc       <= '0;
            pc_load      <= 1'b0;
        end else begin
            pc_load <= 1'b0;
            unique case (sel)
                SEL_RESET: begin
                    cause   <= '0;
                    new_pc  <= '0;
                    pc_load <= 1'b1;
                end
                SEL_NMI: begin
                    nmi_save_pc  <= cur_pc;
                    nmi_save_psw <= psw;
                    cause[CAUSE_W-1:CAUSE_HALF] <= NMI_CAUSE_CODE;
                    new_pc  <= PC_W'(NMI_VECTOR);
                    pc_load <= 1'b1;
                end
                SEL_MASK: begin
                    mi_save_pc  <= cur_pc;
                    mi_save_psw <= psw;
                    cause[CAUSE_HALF-1:0] <= CAUSE_HALF'(mi_vec);
                    new_pc  <= mi_vec;
                    pc_load <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R7
    mask_cause_tracks_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && new_pc >= PC_W'(VEC_BASE)) |-> cause[CAUSE_HALF-1:0] == CAUSE_HALF'(new_pc));

    // R4
    nmi_cause_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && new_pc == PC_W'(NMI_VECTOR)) |-> cause[CAUSE_W-1:CAUSE_HALF] == NMI_CAUSE_CODE);

endmodule

// File: rtl/irq_entry_ctrl.sv
// Top of the interrupt entry controller. It ties together the arbiter,
// the PSW/deferred-NMI state and the save/cause/vector registers.
// Assumes: boundary is a one-cycle strobe from the execution unit, and
// the execution unit loads new_pc whenever pc_load is high.
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int NUM_MI   = 6,
    parameter int VEC_BASE = 32'h80,
    parameter int VEC_STEP = 32'h10,
    localparam int IDX_W   = (NUM_MI > 1) ? $clog2(NUM_MI) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boundary,
    input  logic [PC_W-1:0]    cur_pc,
    input  logic               rst_req,
    input  logic               nmi_req,
    input  logic [NUM_MI-1:0]  mi_req,
    input  logic               psw_wr_en,
    input  logic [PSW_W-1:0]   psw_wr_data,
    input  logic               nmi_ret,
    output logic [PSW_W-1:0]   psw,
    output logic               nmi_pend,
    output logic [CAUSE_W-1:0] cause,
    output logic [PC_W-1:0]    nmi_save_pc,
    output logic [PSW_W-1:0]   nmi_save_psw,
    output logic [PC_W-1:0]    mi_save_pc,
    output logic [PSW_W-1:0]   mi_save_psw,
    output logic [PC_W-1:0]    new_pc,
    output logic               pc_load
);

    entry_sel_e       sel;
    logic [IDX_W-1:0] mi_idx;
    logic             nmi_defer;

    irq_arbiter #(.NUM_MI(NUM_MI)) i_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .boundary  (boundary),
        .rst_req   (rst_req),
        .nmi_req   (nmi_req),
        .nmi_pend  (nmi_pend),
        .psw_id    (psw[PSW_ID_BIT]),
        .psw_np    (psw[PSW_NP_BIT]),
        .mi_req    (mi_req),
        .sel       (sel),
        .mi_idx    (mi_idx),
        .nmi_defer (nmi_defer)
    );

    irq_psw_ctrl i_psw (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .nmi_defer   (nmi_defer),
        .psw_wr_en   (psw_wr_en),
        .psw_wr_data (psw_wr_data),
        .nmi_ret     (nmi_ret),
        .psw         (psw),
        .nmi_pend    (nmi_pend)
    );

    irq_save_regs #(
        .PC_W     (PC_W),
        .NUM_MI   (NUM_MI),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) i_save (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel          (sel),
        .mi_idx       (mi_idx),
        .cur_pc       (cur_pc),
        .psw          (psw),
        .cause        (cause),
        .nmi_save_pc  (nmi_save_pc),
        .nmi_save_psw (nmi_save_psw),
        .mi_save_pc   (mi_save_pc),
        .mi_save_psw  (mi_save_psw),
        .new_pc       (new_pc),
        .pc_load      (pc_load)
    );

    // R2
    load_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> $past(boundary));

    // R7
    entry_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> psw[PSW_ID_BIT] && !psw[PSW_EP_BIT]);

    // R9
    mask_only_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && new_pc >= PC_W'(VEC_BASE)) |-> !$past(psw[PSW_ID_BIT]));

    // R4
    nmi_sets_np_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && new_pc == PC_W'(NMI_VECTOR)) |-> psw[PSW_NP_BIT]);

endmodule

// File: tb/test_irq_entry_ctrl.sv
module test_irq_entry_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        rst_req = 1'b0;
    logic        nmi_req = 1'b0;
    logic [5:0]  mi_req = '0;
    logic        psw_wr_en = 1'b0;
    logic [7:0]  psw_wr_data = '0;
    logic        nmi_ret = 1'b0;
    logic [7:0]  psw;
    logic        nmi_pend;
    logic [31:0] cause;
    logic [31:0] nmi_save_pc;
    logic [7:0]  nmi_save_psw;
    logic [31:0] mi_save_pc;
    logic [7:0]  mi_save_psw;
    logic [31:0] new_pc;
    logic        pc_load;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    irq_entry_ctrl i_irq_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .cur_pc(cur_pc),
        .rst_req(rst_req), .nmi_req(nmi_req), .mi_req(mi_req),
        .psw_wr_en(psw_wr_en), .psw_wr_data(psw_wr_data), .nmi_ret(nmi_ret),
        .psw(psw), .nmi_pend(nmi_pend), .cause(cause),
        .nmi_save_pc(nmi_save_pc), .nmi_save_psw(nmi_save_psw),
        .mi_save_pc(mi_save_pc), .mi_save_psw(mi_save_psw),
        .new_pc(new_pc), .pc_load(pc_load)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated on every clock edge
    logic [7:0]  m_psw;
    logic        m_pend;
    logic [31:0] m_cause, m_fepc, m_eipc, m_npc;
    logic [7:0]  m_fepsw, m_eipsw;
    logic        m_load;
    bit          m_valid = 1'b0;

    always @(posedge clk) begin
        logic [7:0] old_psw;
        logic       took;
        m_valid = 1'b1;
        if (!rst_n) begin
            m_psw = 8'h20; m_pend = 0; m_cause = 0; m_fepc = 0; m_eipc = 0;
            m_fepsw = 0; m_eipsw = 0; m_npc = 0; m_load = 0;
        end else begin
            old_psw = m_psw;
            m_load = 0;
            took = 0;
            if (boundary && rst_req) begin
                m_psw = 8'h20; m_cause = 0; m_npc = 0; m_load = 1; m_pend = 0; took = 1;
            end else if (boundary && (nmi_req || m_pend) && !old_psw[7]) begin
                m_fepc = cur_pc; m_fepsw = old_psw;
                m_psw = (old_psw | 8'hA0) & ~8'h40;
                m_cause = {16'h0010, m_cause[15:0]};
                m_npc = 32'h10; m_load = 1; m_pend = 0; took = 1;
            end else if (boundary && mi_req != 0 && !old_psw[5]) begin
                for (int i = 5; i >= 0; i--)
                    if (mi_req[i]) m_npc = 32'h80 + 32'h10 * i;
                m_eipc = cur_pc; m_eipsw = old_psw;
                m_psw = (old_psw | 8'h20) & ~8'h40;
                m_cause = {m_cause[31:16], m_npc[15:0]};
                m_load = 1; took = 1;
            end
            if (boundary && !rst_req && nmi_req && old_psw[7]) m_pend = 1;
            if (!took) begin
                if (psw_wr_en) m_psw = psw_wr_data;
                else if (nmi_ret) m_psw = old_psw & ~8'h80;
            end
        end
    end

    // Compare every output with the model between clock edges
    always @(negedge clk) begin
        if (m_valid && !done) begin
            chk("MODEL pc_load", {31'd0, pc_load}, {31'd0, m_load});
            chk("MODEL new_pc", new_pc, m_npc);
            chk("MODEL psw", {24'd0, psw}, {24'd0, m_psw});
            chk("MODEL pend", {31'd0, nmi_pend}, {31'd0, m_pend});
            chk("MODEL cause", cause, m_cause);
            chk("MODEL nmi_save_pc", nmi_save_pc, m_fepc);
            chk("MODEL nmi_save_psw", {24'd0, nmi_save_psw}, {24'd0, m_fepsw});
            chk("MODEL mi_save_pc", mi_save_pc, m_eipc);
            chk("MODEL mi_save_psw", {24'd0, mi_save_psw}, {24'd0, m_eipsw});
        end
    end

    // Present one cycle of stimulus, then return to idle
    task automatic cyc(input logic b, input logic r, input logic n,
                       input logic [5:0] m, input logic [31:0] pc);
        boundary = b; rst_req = r; nmi_req = n; mi_req = m; cur_pc = pc;
        @(negedge clk);
        boundary = 0; rst_req = 0; nmi_req = 0; mi_req = 0;
    endtask

    task automatic wr_psw(input logic [7:0] v);
        psw_wr_en = 1; psw_wr_data = v;
        @(negedge clk);
        psw_wr_en = 0;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 psw", {24'd0, psw}, 32'h20);
        chk("R1 cause", cause, 0);
        chk("R1 pc_load", {31'd0, pc_load}, 0);
        chk("R1 pend", {31'd0, nmi_pend}, 0);
        rst_n = 1;
        @(negedge clk);

        // R9 maskable ignored while ID set
        cyc(1, 0, 0, 6'h3F, 32'h100);
        chk("R9 no entry with ID", {31'd0, pc_load}, 0);

        // R2 no entry without a boundary
        wr_psw(8'h00);
        cyc(0, 0, 0, 6'h3F, 32'h104);
        chk("R2 no boundary", {31'd0, pc_load}, 0);

        // R8 R7 lowest line wins among several
        cyc(1, 0, 0, 6'b101100, 32'h200);
        chk("R8 lowest line vector", new_pc, 32'hA0);
        chk("R2 load strobe", {31'd0, pc_load}, 1);
        chk("R7 cause low", cause, 32'hA0);
        chk("R7 mi_save_pc", mi_save_pc, 32'h200);
        chk("R7 mi_save_psw", {24'd0, mi_save_psw}, 0);
        chk("R7 psw ID set", {24'd0, psw}, 32'h20);
        @(negedge clk);
        chk("R2 strobe one cycle", {31'd0, pc_load}, 0);

        // R8 every line alone
        for (int i = 0; i < 6; i++) begin
            wr_psw(8'h40);
            cyc(1, 0, 0, 6'(1 << i), 32'h300 + 32'(i));
            chk("R8 single line vector", new_pc, 32'h80 + 32'h10 * i);
            chk("R7 EP cleared", {31'd0, psw[6]}, 0);
        end

        // R4 R9 NMI taken while ID set
        cyc(1, 0, 1, 6'h00, 32'h1234);
        chk("R4 nmi vector", new_pc, 32'h10);
        chk("R4 nmi_save_pc", nmi_save_pc, 32'h1234);
        chk("R4 nmi_save_psw", {24'd0, nmi_save_psw}, 32'h20);
        chk("R4 psw NP ID", {24'd0, psw}, 32'hA0);
        chk("R4 cause fields", cause, 32'h0010_00D0);

        // R5 R6 NMI while NP set is deferred, repeats dropped
        cyc(1, 0, 1, 6'h00, 32'h2000);
        chk("R5 no entry", {31'd0, pc_load}, 0);
        chk("R5 pend set", {31'd0, nmi_pend}, 1);
        chk("R5 save kept", nmi_save_pc, 32'h1234);
        cyc(1, 0, 1, 6'h00, 32'h2004);
        chk("R6 pend stays", {31'd0, nmi_pend}, 1);

        // R11 return clears NP, deferred NMI taken at next boundary
        nmi_ret = 1; @(negedge clk); nmi_ret = 0;
        chk("R11 NP cleared", {31'd0, psw[7]}, 0);
        chk("R11 no entry on return", {31'd0, pc_load}, 0);
        cyc(1, 0, 0, 6'h00, 32'h3000);
        chk("R11 deferred taken", new_pc, 32'h10);
        chk("R11 pend cleared", {31'd0, nmi_pend}, 0);
        chk("R6 saved pc", nmi_save_pc, 32'h3000);
        nmi_ret = 1; @(negedge clk); nmi_ret = 0;
        cyc(1, 0, 0, 6'h00, 32'h3010);
        chk("R6 only one deferred", {31'd0, pc_load}, 0);

        // R10 R3 reset beats everything
        wr_psw(8'h00);
        cyc(1, 1, 1, 6'h3F, 32'h4000);
        chk("R10 reset first", new_pc, 0);
        chk("R3 psw", {24'd0, psw}, 32'h20);
        chk("R3 cause cleared", cause, 0);

        // R10 NMI beats maskable
        wr_psw(8'h00);
        cyc(1, 0, 1, 6'h3F, 32'h5000);
        chk("R10 nmi over maskable", new_pc, 32'h10);

        // R10 R5 with NP set, maskable taken and NMI deferred
        wr_psw(8'h80);
        cyc(1, 0, 1, 6'b001000, 32'h6000);
        chk("R10 maskable while NP", new_pc, 32'hB0);
        chk("R5 pend with maskable", {31'd0, nmi_pend}, 1);

        // R3 reset request clears deferred flag
        cyc(1, 1, 0, 6'h00, 32'h7000);
        chk("R3 pend cleared", {31'd0, nmi_pend}, 0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule